// File: doc/BRIEF.md
# Received Frame Depackager

This block sits between a baseband byte decoder and a microprocessor. The decoder offers received frame bytes one at a time with a ready-to-send strobe. The block takes each byte and answers with a one-cycle ready-to-receive pulse. A fixed number of leading header bytes are counted and then dropped. The byte after them carries the frame length. That length value goes to a fixed upper RAM location, and it also loads a down-counter. The counter supplies a descending write address for each payload byte.

Each payload byte also passes through a 16-bit CRC register. When the last payload byte has been stored, the two CRC bytes are written to the two locations just above the length. The block then enters a read-out phase. In that phase the microprocessor fetches any RAM location through a request/acknowledge handshake. Reading the all-ones status address ends the phase, and the block goes back to waiting for the next frame's header.

Top module: `frame_depacker`

## Requirements
- R1: A synchronous active-high reset drives `rtr`, `ack` and `rdata` low, zeroes the CRC and restarts header counting, so the next accepted byte counts as header byte one.
- R2: In the receive phase, a byte is accepted at a clock edge where `rts`=1 and `rtr`=0. `rtr` is high for exactly the one following cycle.
- R3: The first five accepted bytes are discarded. The sixth is the frame length N and is stored at address 128.
- R4: Payload byte i (counting from 0) of a frame of length N is stored at address N-1-i. N must not exceed 128.
- R5: The CRC uses polynomial x^16+x^12+x^5+1 with a zero start value and takes each byte least-significant bit first (reflected constant 0x8408). Its low byte is stored at address 129 and its high byte at address 130.
- R6: A payload whose last two bytes are its own CRC, low byte then high byte, stores 0x00 at addresses 129 and 130.
- R7: A frame length of 0 writes address 128 and a zero CRC at 129 and 130. No payload location is changed, and the read-out phase follows.
- R8: In the read-out phase, a request is taken at an edge where `req`=1 and `ack`=0. In the next cycle `ack` is high for one cycle and `rdata` holds RAM[`addr`]. `rdata` keeps that value until the next accepted request.
- R9: An accepted request to address 255 ends the read-out phase. The next decoder byte is then counted as header byte one.
- R10: `req` gets no `ack` during reception. `rts` gets no `rtr` during read-out and leaves RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts | input | 1 | Decoder offers a byte |
| din | input | 8 | Byte from the decoder |
| rtr | output | 1 | One-cycle pulse: byte taken |
| req | input | 1 | Microprocessor read request |
| addr | input | 8 | Microprocessor read address |
| ack | output | 1 | One-cycle pulse: read served |
| rdata | output | 8 | RAM data of the last served read |

## Verification
A header counter that is off by one shows up as a wrong value at address 128 and a shifted payload at the first read-back of a frame. A down-counter that slips leaves payload bytes at the wrong addresses, or overwrites address 0 when the length is zero. A CRC register that is not cleared between frames, or that uses the wrong bit order, shows up at addresses 129 and 130 of the next frame, and also as a non-zero residue when the payload ends with its own CRC. A phase state that is wrong becomes visible within one handshake, as a missing or unexpected `rtr` or `ack` pulse.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_HDR,
    ST_LEN,
    ST_PAY,
    ST_CRCL,
    ST_CRCH,
    ST_READ
  } fdp_state_t;

  // bit-reversed form of x^16+x^12+x^5+1
  localparam logic [15:0] FDP_POLY_REV = 16'h8408;
endpackage

// File: rtl/fdp_crc.sv
module fdp_crc #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY_REV = fdp_pkg::FDP_POLY_REV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);
  logic [CW-1:0] nxt;

  // LSB-first serial division, unrolled over one byte
  always_comb begin
    nxt = crc ^ CW'(din);
    for (int i = 0; i < DW; i++) begin
      if (nxt[0]) nxt = (nxt >> 1) ^ POLY_REV;
      else        nxt = nxt >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= nxt;
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(crc)); // R5
  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == '0)); // R9
endmodule

// File: rtl/fdp_ram.sv
module fdp_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with resettable output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    we |-> !$isunknown(waddr)); // R4
endmodule

// File: rtl/frame_depacker.sv
module frame_depacker #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int HDR_LEN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rts,
  input  logic [DW-1:0] din,
  output logic          rtr,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  import fdp_pkg::*;

  localparam int             HCW       = $clog2(HDR_LEN + 1);
  localparam logic [AW-1:0]  A_LEN     = AW'(1) << (AW - 1);
  localparam logic [AW-1:0]  A_CRCL    = A_LEN + AW'(1);
  localparam logic [AW-1:0]  A_CRCH    = A_LEN + AW'(2);
  localparam logic [AW-1:0]  A_STAT    = '1;
  localparam logic [HCW-1:0] HDR_LAST  = HCW'(HDR_LEN - 1);

  fdp_state_t     state;
  logic [HCW-1:0] hcnt;
  logic [DW-1:0]  dcnt;
  logic [15:0]    crc;

  logic           rx_phase, take, rd_take, rd_exit;
  logic           we;
  logic [AW-1:0]  waddr;
  logic [DW-1:0]  wdata;

  assign rx_phase = (state == ST_HDR) || (state == ST_LEN) || (state == ST_PAY);
  assign take     = rx_phase && rts && !rtr;
  assign rd_take  = (state == ST_READ) && req && !ack;
  assign rd_exit  = rd_take && (addr == A_STAT);

  // write-side address and data multiplexers
  always_comb begin
    we    = 1'b0;
    waddr = A_LEN;
    wdata = din;
    unique case (state)
      ST_LEN:  begin we = take; waddr = A_LEN; wdata = din; end
      ST_PAY:  begin we = take; waddr = AW'(dcnt - 1'b1); wdata = din; end
      ST_CRCL: begin we = 1'b1; waddr = A_CRCL; wdata = DW'(crc[7:0]); end
      ST_CRCH: begin we = 1'b1; waddr = A_CRCH; wdata = DW'(crc[15:8]); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HDR;
      hcnt  <= '0;
      dcnt  <= '0;
      rtr   <= 1'b0;
      ack   <= 1'b0;
    end else begin
      rtr <= take;
      ack <= rd_take;
      unique case (state)
        ST_HDR: if (take) begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == HDR_LAST) state <= ST_LEN;
        end
        ST_LEN: if (take) begin
          dcnt  <= din;
          state <= (din == '0) ? ST_CRCL : ST_PAY;
        end
        ST_PAY: if (take) begin
          dcnt <= dcnt - 1'b1;
          if (dcnt == DW'(1)) state <= ST_CRCL;
        end
        ST_CRCL: state <= ST_CRCH;
        ST_CRCH: state <= ST_READ;
        ST_READ: if (rd_exit) begin
          state <= ST_HDR;
          hcnt  <= '0;
        end
        default: state <= ST_HDR;
      endcase
    end
  end

  fdp_crc #(.DW(DW), .CW(16)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (rd_exit),
    .en  (take && (state == ST_PAY)),
    .din (din),
    .crc (crc)
  );

  fdp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .re    (rd_take),
    .raddr (addr),
    .rdata (rdata)
  );

  AST_RTR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rtr |=> !rtr); // R2
  AST_RTR_FROM_RTS: assert property (@(posedge clk) disable iff (rst)
    rtr |-> $past(rts)); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8
  AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(req)); // R8
  AST_NO_RTR_IN_READ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |-> !rtr); // R10
  AST_NO_ACK_IN_RX: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READ && $past(state) != ST_READ) |-> !ack); // R10
  AST_PAY_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAY) |-> (dcnt != '0)); // R4
  AST_HDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR) |-> (hcnt <= HDR_LAST)); // R3
endmodule

// File: tb/sim_frame_depacker.sv
module sim_frame_depacker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rts = 1'b0;
  logic [7:0] din = '0;
  logic       req = 1'b0;
  logic [7:0] addr = '0;
  logic       rtr, ack;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] pay [256];

  // {length, seed}
  localparam int NV = 4;
  localparam logic [15:0] VEC [NV] = '{16'h013C, 16'h0591, 16'h11C7, 16'h8022};

  always #4 clk = ~clk;

  frame_depacker u0 (
    .clk(clk), .rst(rst), .rts(rts), .din(din), .rtr(rtr),
    .req(req), .addr(addr), .ack(ack), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pay[i]};
      for (int b = 0; b < 8; b++)
        c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit check_rtr);
    @(negedge clk);
    rts = 1'b1; din = b;
    @(negedge clk);
    if (check_rtr) chk("R2 rtr pulse", {15'd0, rtr}, 16'd1);
    rts = 1'b0;
    @(negedge clk);
    if (check_rtr) chk("R2 rtr single cycle", {15'd0, rtr}, 16'd0);
  endtask

  task automatic send_frame(input int n);
    for (int j = 0; j < 5; j++) send_byte(8'hA0 + 8'(j), 1'b0);
    send_byte(8'(n), 1'b1);
    for (int i = 0; i < n; i++) send_byte(pay[i], 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic got_ack);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    got_ack = ack; d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d; logic g;
    rd(a, d, g);
    chk({tag, " ack"}, {15'd0, g}, 16'd1);
    chk(tag, {8'd0, d}, {8'd0, exp});
  endtask

  task automatic exit_read();
    logic [7:0] d; logic g;
    rd(8'hFF, d, g);
    chk("R9 exit ack", {15'd0, g}, 16'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c;
    logic [7:0] d; logic g;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rtr reset", {15'd0, rtr}, 16'd0);
    chk("R1 ack reset", {15'd0, ack}, 16'd0);
    chk("R1 rdata reset", {8'd0, rdata}, 16'd0);
    rst = 1'b0;

    // R10: requests during reception get no ack
    @(negedge clk); req = 1'b1; addr = 8'h80;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no ack while receiving", {15'd0, ack}, 16'd0);
    end
    req = 1'b0;

    // table-driven frames: R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      int n;
      n = int'(VEC[v][15:8]);
      for (int i = 0; i < n; i++) pay[i] = (VEC[v][7:0] + 8'(i * 29)) ^ 8'h5A;
      send_frame(n);
      c = crc_ref(n);
      rd_chk("R3 length at 128", 8'h80, 8'(n));
      for (int i = 0; i < n; i++) rd_chk("R4 payload order", 8'(n - 1 - i), pay[i]);
      rd_chk("R5 crc low", 8'h81, c[7:0]);
      rd_chk("R5 crc high", 8'h82, c[15:8]);
      exit_read();
    end

    // R8: rdata held between requests
    for (int i = 0; i < 3; i++) pay[i] = 8'h11 * 8'(i + 1);
    send_frame(3);
    rd_chk("R8 read data", 8'h00, 8'h33);
    repeat (4) @(negedge clk);
    chk("R8 rdata held", {8'd0, rdata}, 16'h0033);
    chk("R8 ack low when idle", {15'd0, ack}, 16'd0);

    // R10: rts ignored during read-out
    @(negedge clk); rts = 1'b1; din = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no rtr in read-out", {15'd0, rtr}, 16'd0);
    end
    rts = 1'b0;
    rd_chk("R10 RAM unchanged", 8'h00, 8'h33);
    rd_chk("R10 length unchanged", 8'h80, 8'h03);
    exit_read();

    // R6: payload ending with its own CRC
    for (int i = 0; i < 6; i++) pay[i] = 8'h30 + 8'(i * 7);
    c = crc_ref(6);
    pay[6] = c[7:0]; pay[7] = c[15:8];
    send_frame(8);
    rd_chk("R6 residue low", 8'h81, 8'h00);
    rd_chk("R6 residue high", 8'h82, 8'h00);
    rd_chk("R6 appended low byte", 8'h01, c[7:0]);
    exit_read();

    // R7: zero length
    send_frame(0);
    rd_chk("R7 length zero", 8'h80, 8'h00);
    rd_chk("R7 crc low zero", 8'h81, 8'h00);
    rd_chk("R7 crc high zero", 8'h82, 8'h00);
    rd_chk("R7 payload untouched", 8'h00, pay[7]);
    exit_read();

    // R9: after exit, no ack (receiving again)
    rd(8'h80, d, g);
    chk("R9 back in reception", {15'd0, g}, 16'd0);

    // R1: reset mid-header restarts counting
    send_byte(8'h01, 1'b0);
    send_byte(8'h02, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    pay[0] = 8'h9C; pay[1] = 8'h4D;
    send_frame(2);
    c = crc_ref(2);
    rd_chk("R1 length after reset", 8'h80, 8'h02);
    rd_chk("R1 payload after reset", 8'h01, 8'h9C);
    rd_chk("R1 crc low after reset", 8'h81, c[7:0]);
    exit_read();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule